// File: doc/BRIEF.md
# Dual-Compare Pulse Generator

This block drives one output pin with pulses whose edges are placed by two compare values. A rise compare value sets the pin high when the selected time base reaches it, and a fall compare value sets the pin low again. The time base is one of two internal up-counters. Each counter runs only while its run bit is set, and it returns to zero on the cycle after it equals its own period value. A one-shot mode produces a single pulse and then stays quiet. A train mode repeats the pulse once in every counter period.

Software programs the block through a simple write port made of an address, a data word and a write strobe. A trailing-edge match raises a sticky flag. A software write clears the flag. An interrupt request output is the flag qualified by an enable bit. A new one-shot pulse is started by writing the control word again. The channel does not have to be disabled first, and the counter does not have to be cleared.

Top module: `pulse_compare_unit`

## Requirements
- R1: After reset the pin, the flag and the request are low, both counters are zero and stopped, and the mode field is 3'b000.
- R2: Any write to address 0 (control word: bits [2:0] mode, bit 3 timer select, bit 4 request enable) forces the pin low at that clock edge, whatever the old state was.
- R3: In an active mode, when the selected running counter equals the rise value (address 5), the pin is high from the next clock edge.
- R4: When the selected running counter equals the fall value (address 6), the pin is low from the next edge. If the rise and fall values are equal, the fall takes precedence.
- R5: In one-shot mode (3'b100), after the trailing-edge match there is no further rise and no further flag until address 0 is written again.
- R6: Every trailing-edge match in an active, non-finished channel sets the flag. The request output is high only while the flag is high and the enable bit (control bit 4) is 1.
- R7: Counter n (n = 0 or 1) is controlled at address 1+n: bit 0 is run and bit 1 zeroes the count. Its period value is at address 3+n. While running, the counter advances by one per cycle and goes to 0 on the cycle after it equals its period value.
- R8: In train mode (3'b101) the rise and fall repeat once every period+1 cycles for as long as the mode is held.
- R9: Writing 3'b100 again re-arms a finished one-shot channel without stopping or clearing the counter, and exactly one more pulse follows.
- R10: Control bit 3 selects counter 1 (1) or counter 0 (0) as the time base. No match has an effect while the selected counter is stopped.
- R11: If the period is below the fall value, the fall match never occurs and the pin keeps its level.
- R12: The flag stays set until a write to address 7 with bit 0 = 1 clears it. A trailing-edge match in the same cycle as the clear wins, and the flag stays set.
- R13: Any mode value other than 3'b100 or 3'b101 holds the pin low and generates no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data |
| pulse_out | output | 1 | Pulse pin |
| irq_flag | output | 1 | Sticky trailing-edge flag |
| irq_req | output | 1 | Flag qualified by the enable bit |

## Verification
The hardest case to reach from the ports is a flag clear that falls in exactly the cycle of a trailing-edge match. A random clear would hit that cycle only rarely. The bench therefore runs a cycle-accurate model of the register and counter state. It waits until the model shows that the fall match is due at the next edge, and only then issues the clear. A period set below the fall value, after the counter has been zeroed, is driven in the same directed way. Long constrained-random runs then mix mode rewrites, timer stops and period changes against the model.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int NTMR = 2;
  localparam int AW   = 3;

  typedef enum logic [AW-1:0] {
    A_CTRL = 3'd0,
    A_T0   = 3'd1,
    A_T1   = 3'd2,
    A_PER0 = 3'd3,
    A_PER1 = 3'd4,
    A_RISE = 3'd5,
    A_FALL = 3'd6,
    A_FLAG = 3'd7
  } addr_e;

  localparam logic [2:0] M_ONE   = 3'b100;
  localparam logic [2:0] M_TRAIN = 3'b101;
endpackage

// File: rtl/pcu_regs.sv
module pcu_regs
  import pcu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [CNT_W-1:0]            wr_data,
  output logic [2:0]                  mode_q,
  output logic                        tsel_q,
  output logic                        ie_q,
  output logic [NTMR-1:0]             ten_q,
  output logic [NTMR-1:0]             tclr,
  output logic [NTMR-1:0][CNT_W-1:0]  per_q,
  output logic [CNT_W-1:0]            pri_q,
  output logic [CNT_W-1:0]            sec_q,
  output logic                        mode_wr,
  output logic                        flag_clr
);
  assign mode_wr  = wr_en && (wr_addr == A_CTRL);
  assign flag_clr = wr_en && (wr_addr == A_FLAG) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      tsel_q <= 1'b0;
      ie_q   <= 1'b0;
      pri_q  <= '0;
      sec_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) begin
        mode_q <= wr_data[2:0];
        tsel_q <= wr_data[3];
        ie_q   <= wr_data[4];
      end
      if (wr_addr == A_RISE) pri_q <= wr_data;
      if (wr_addr == A_FALL) sec_q <= wr_data;
    end
  end

  for (genvar i = 0; i < NTMR; i++) begin : g_treg
    localparam logic [AW-1:0] TA = AW'(int'(A_T0) + i);
    localparam logic [AW-1:0] PA = AW'(int'(A_PER0) + i);
    logic             run_r;
    logic [CNT_W-1:0] per_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        run_r <= 1'b0;
        per_r <= '0;
      end else if (wr_en) begin
        if (wr_addr == TA) run_r <= wr_data[0];
        if (wr_addr == PA) per_r <= wr_data;
      end
    end

    assign ten_q[i] = run_r;
    assign per_q[i] = per_r;
    assign tclr[i]  = wr_en && (wr_addr == TA) && wr_data[1];
  end
endmodule

// File: rtl/pcu_timer.sv
module pcu_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             zero,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || zero) count <= '0;
    else if (run)    count <= (count == period) ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/pcu_channel.sv
module pcu_channel
  import pcu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic             mode_wr,
  input  logic             flag_clr,
  input  logic             run,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] pri,
  input  logic [CNT_W-1:0] sec,
  input  logic             ie,
  output logic             pulse_out,
  output logic             irq_flag,
  output logic             irq_req
);
  logic single, active, done_q, live, hit_rise, hit_fall;

  assign single   = (mode == M_ONE);
  assign active   = single || (mode == M_TRAIN);
  assign hit_rise = (count == pri);
  assign hit_fall = (count == sec);
  assign live     = active && run && !done_q && !mode_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_out <= 1'b0;
      done_q    <= 1'b0;
      irq_flag  <= 1'b0;
    end else begin
      if (mode_wr || !active) begin
        pulse_out <= 1'b0;
        done_q    <= 1'b0;
      end else if (live) begin
        if (hit_fall) begin
          pulse_out <= 1'b0;
          done_q    <= single;
        end else if (hit_rise) begin
          pulse_out <= 1'b1;
        end
      end
      if (live && hit_fall) irq_flag <= 1'b1;
      else if (flag_clr)    irq_flag <= 1'b0;
    end
  end

  assign irq_req = irq_flag & ie;
endmodule

// File: rtl/pulse_compare_unit.sv
module pulse_compare_unit
  import pcu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pulse_out,
  output logic             irq_flag,
  output logic             irq_req
);
  logic [2:0]                 mode_q;
  logic                       tsel_q, ie_q, mode_wr, flag_clr;
  logic [NTMR-1:0]            ten_q, tclr;
  logic [NTMR-1:0][CNT_W-1:0] per_q, cnt;
  logic [CNT_W-1:0]           pri_q, sec_q, sel_cnt;
  logic                       sel_run;

  pcu_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_q(mode_q), .tsel_q(tsel_q), .ie_q(ie_q), .ten_q(ten_q), .tclr(tclr),
    .per_q(per_q), .pri_q(pri_q), .sec_q(sec_q), .mode_wr(mode_wr),
    .flag_clr(flag_clr)
  );

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    pcu_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst(rst), .run(ten_q[i]), .zero(tclr[i]),
      .period(per_q[i]), .count(cnt[i])
    );
  end

  assign sel_cnt = cnt[tsel_q];
  assign sel_run = ten_q[tsel_q];

  pcu_channel #(.CNT_W(CNT_W)) u_chan (
    .clk(clk), .rst(rst), .mode(mode_q), .mode_wr(mode_wr),
    .flag_clr(flag_clr), .run(sel_run), .count(sel_cnt), .pri(pri_q),
    .sec(sec_q), .ie(ie_q), .pulse_out(pulse_out), .irq_flag(irq_flag),
    .irq_req(irq_req)
  );
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_wr,
  input logic             flag_clr,
  input logic [2:0]       mode_q,
  input logic             sel_run,
  input logic [CNT_W-1:0] sel_cnt,
  input logic [CNT_W-1:0] sec_q,
  input logic             pulse_out,
  input logic             irq_flag,
  input logic             irq_req
);
  logic on;
  assign on = (mode_q == 3'b100) || (mode_q == 3'b101);

  // R2
  ctrl_write_low_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> !pulse_out);

  // R4
  fall_match_chk: assert property (@(posedge clk) disable iff (rst)
    (on && sel_run && (sel_cnt == sec_q) && !mode_wr) |=> !pulse_out);

  // R6
  req_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_flag |-> !irq_req);

  // R12
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !flag_clr) |=> irq_flag);

  // R13
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!on && !mode_wr) |=> !pulse_out);

  // R13
  idle_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    (!on && !irq_flag) |=> !irq_flag);
endmodule

bind pulse_compare_unit pcu_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mode_wr(mode_wr), .flag_clr(flag_clr),
  .mode_q(mode_q), .sel_run(sel_run), .sel_cnt(sel_cnt), .sec_q(sec_q),
  .pulse_out(pulse_out), .irq_flag(irq_flag), .irq_req(irq_req)
);

// File: tb/pulse_compare_unit_test.sv
module pulse_compare_unit_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         pulse_out, irq_flag, irq_req;

  int checks = 0;
  int errors = 0;
  bit model_on = 0;

  always #5 clk = ~clk;

  pulse_compare_unit #(.CNT_W(W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pulse_out(pulse_out), .irq_flag(irq_flag), .irq_req(irq_req)
  );

  // reference state
  logic [W-1:0] m_cnt [2];
  logic [W-1:0] m_per [2];
  logic         m_run [2];
  logic [W-1:0] m_pri, m_sec, sc;
  logic [2:0]   m_mode;
  logic         m_tsel, m_ie, m_out, m_done, m_flag;
  logic         act, mw, fc, live;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = '0; m_per[i] = '0; m_run[i] = 1'b0;
      end
      m_pri = '0; m_sec = '0; m_mode = '0; m_tsel = 0; m_ie = 0;
      m_out = 0; m_done = 0; m_flag = 0;
    end else begin
      sc   = m_cnt[m_tsel];
      act  = (m_mode == 3'b100) || (m_mode == 3'b101);
      mw   = wr_en && (wr_addr == 3'd0);
      fc   = wr_en && (wr_addr == 3'd7) && wr_data[0];
      live = act && m_run[m_tsel] && !m_done && !mw;
      if (mw || !act) begin
        m_out = 0; m_done = 0;
      end else if (live) begin
        if (sc == m_sec) begin
          m_out = 0; m_done = (m_mode == 3'b100);
        end else if (sc == m_pri) m_out = 1;
      end
      if (live && sc == m_sec) m_flag = 1;
      else if (fc) m_flag = 0;
      for (int i = 0; i < 2; i++) begin
        if (wr_en && wr_addr == 3'(1 + i) && wr_data[1]) m_cnt[i] = '0;
        else if (m_run[i]) m_cnt[i] = (m_cnt[i] == m_per[i]) ? '0 : m_cnt[i] + 1'b1;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_mode = wr_data[2:0]; m_tsel = wr_data[3]; m_ie = wr_data[4]; end
          3'd1: m_run[0] = wr_data[0];
          3'd2: m_run[1] = wr_data[0];
          3'd3: m_per[0] = wr_data;
          3'd4: m_per[1] = wr_data;
          3'd5: m_pri = wr_data;
          3'd6: m_sec = wr_data;
          default: ;
        endcase
      end
    end
  end

  function automatic bit fall_due();
    return ((m_mode == 3'b100) || (m_mode == 3'b101)) && m_run[m_tsel]
           && !m_done && (m_cnt[m_tsel] == m_sec);
  endfunction

  task automatic chk(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // R3 R4 R6 R12: cycle-by-cycle comparison with the reference state
  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk("R3 R4 model pulse_out", int'(pulse_out), int'(m_out));
      chk("R6 R12 model irq_flag", int'(irq_flag), int'(m_flag));
      chk("R6 model irq_req", int'(irq_req), int'(m_flag & m_ie));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_rises(input int n, output int r);
    logic prev;
    r = 0;
    prev = pulse_out;
    repeat (n) begin
      @(negedge clk);
      if (pulse_out && !prev) r++;
      prev = pulse_out;
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    int r;
    int guard;
    logic [2:0]   ra;
    logic [W-1:0] rd;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset pulse_out", int'(pulse_out), 0);
    chk("R1 reset irq_flag", int'(irq_flag), 0);
    chk("R1 reset irq_req", int'(irq_req), 0);
    model_on = 1;

    // one-shot, timer 0: period 9, rise 3, fall 6
    wr(3'd3, 16'd9); wr(3'd5, 16'd3); wr(3'd6, 16'd6); wr(3'd0, 16'h14);
    wr(3'd1, 16'd1);
    repeat (3) @(negedge clk);
    chk("R3 before rise", int'(pulse_out), 0);
    @(negedge clk);
    chk("R3 rise after count==3", int'(pulse_out), 1);
    repeat (2) @(negedge clk);
    chk("R4 still high", int'(pulse_out), 1);
    @(negedge clk);
    chk("R4 fall after count==6", int'(pulse_out), 0);
    chk("R6 flag set on fall", int'(irq_flag), 1);
    chk("R6 request with enable", int'(irq_req), 1);
    count_rises(30, r);
    chk("R5 no second pulse", r, 0);
    chk("R12 flag sticky", int'(irq_flag), 1);

    // R9 re-arm
    wr(3'd0, 16'h14);
    count_rises(25, r);
    chk("R9 re-arm gives one pulse", r, 1);

    // R8 R7 train mode, period 10 cycles
    wr(3'd0, 16'h15);
    repeat (10) @(negedge clk);
    count_rises(40, r);
    chk("R8 R7 train rises in 40 cycles", r, 4);

    // R2 write while high
    guard = 0;
    while (!pulse_out && guard < 40) begin @(negedge clk); guard++; end
    chk("R2 reached high", int'(pulse_out), 1);
    wr(3'd0, 16'h15);
    chk("R2 control write drives low", int'(pulse_out), 0);

    // R10 select timer 1 with period 4 (5 cycles)
    wr(3'd4, 16'd4); wr(3'd5, 16'd1); wr(3'd6, 16'd3); wr(3'd2, 16'd3);
    wr(3'd0, 16'h1D);
    repeat (10) @(negedge clk);
    count_rises(50, r);
    chk("R10 R7 timer1 rises in 50 cycles", r, 10);

    // R11 period below fall value
    wr(3'd4, 16'd2); wr(3'd2, 16'd3); wr(3'd7, 16'd1);
    repeat (30) @(negedge clk);
    chk("R11 pin holds high", int'(pulse_out), 1);
    chk("R11 no fall flag", int'(irq_flag), 0);

    // R12 clear in the same cycle as a fall match
    wr(3'd4, 16'd4);
    guard = 0;
    while (!fall_due() && guard < 40) begin @(negedge clk); guard++; end
    wr(3'd7, 16'd1);
    chk("R12 set wins over clear", int'(irq_flag), 1);
    @(negedge clk);
    chk("R12 clear slot has no match", int'(fall_due()), 0);
    wr(3'd7, 16'd1);
    chk("R12 clear without match", int'(irq_flag), 0);

    // R6 enable gating
    repeat (6) @(negedge clk);
    chk("R6 flag set again", int'(irq_flag), 1);
    wr(3'd0, 16'h0D);
    chk("R6 request off without enable", int'(irq_req), 0);
    chk("R6 flag unaffected by enable", int'(irq_flag), 1);

    // R10 R7 stopped selected timer: no matches
    wr(3'd2, 16'd0);
    count_rises(30, r);
    chk("R10 stopped timer no rise", r, 0);
    wr(3'd2, 16'd1);

    // R13 unused modes
    wr(3'd7, 16'd1); wr(3'd0, 16'h1E);
    count_rises(20, r);
    chk("R13 mode 110 no rise", r, 0);
    chk("R13 mode 110 no flag", int'(irq_flag), 0);
    wr(3'd0, 16'h10);
    count_rises(20, r);
    chk("R13 mode 000 no rise", r, 0);
    chk("R13 mode 000 pin low", int'(pulse_out), 0);

    // constrained random phase
    repeat (4000) begin
      if ($urandom_range(0, 3) == 0) begin
        ra = 3'($urandom_range(0, 7));
        case (ra)
          3'd0: rd = W'({$urandom_range(0, 1), $urandom_range(0, 1),
                         ($urandom_range(0, 4) == 0) ? 3'($urandom_range(0, 7))
                                                     : 3'(3'b100 + $urandom_range(0, 1))});
          3'd1, 3'd2: rd = W'({($urandom_range(0, 5) == 0), ($urandom_range(0, 7) != 0)});
          3'd7: rd = W'($urandom_range(0, 1));
          default: rd = W'($urandom_range(0, 12));
        endcase
        wr(ra, rd);
      end else begin
        @(negedge clk);
      end
    end

    model_on = 0;
    summary();
    $finish;
  end
endmodule